// File: doc/BRIEF.md
# Multichannel First-Order CIC Decimator with Shared Comb

This block reduces the sample rate of several channels that share one clock, using a first-order cascaded integrator-comb filter. Every channel has its own running-sum integrator, which adds that channel's input on every clock. Once per decimation period, all integrator values are copied at the same time into a shift chain. The chain then moves them, one per clock, into a single subtractor. The subtractor takes each value minus the value of the same channel from the previous period. The results leave as a channel-serial stream that carries a channel index.

The decimation ratio is an input that may change at run time. Integrators, chain and comb use wrapping two's-complement arithmetic that is wide enough for the full filter gain. Because of this, any wrap inside an integrator cancels in the difference.

Top module: `cic_conveyor_decim`

## Requirements
- R1: While reset is asserted, and until the first output group, `out_valid` is 0, `out_data` is 0 and `out_chan` is 0.
- R2: Every clock, each channel adds the sign-extended value of its input lane. Lane c is `in_data[c*IN_W +: IN_W]`. The output for channel c is the sum of that lane over the effective-ratio clocks since the previous snapshot, taken modulo 2^ACC_W and read as signed.
- R3: The output width is ACC_W = IN_W + RATIO_W. With every input at -2^(IN_W-1) and a ratio of 255, the output is exactly -2^(IN_W-1)*255, with no wrap.
- R4: The effective ratio is max(`ratio`, NCH), and `ratio` is read every clock. A snapshot is taken at the clock edge where the period counter has reached the effective ratio minus one. The first snapshot after reset is at edge number effective-ratio. Consecutive groups start exactly effective-ratio clocks apart, so load strobes are never closer than NCH clocks.
- R5: After each snapshot, `out_valid` is high for exactly NCH consecutive clocks. `out_chan` runs 0, 1, ... NCH-1 over those clocks, and each beat carries that channel's result.
- R6: The comb history is cleared by reset, so the first group after reset carries the raw integrator sums since reset.
- R7: While `out_valid` is low, `out_data` keeps its last value.
- R8: When the effective ratio equals NCH, groups follow with no idle clock between them and no beat is lost. The last beat of one group and the loading of the next group fall in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | NCH*IN_W | Signed input samples, lane c at bits c*IN_W upward |
| ratio | input | RATIO_W | Requested decimation ratio, raised to NCH if smaller |
| out_data | output | ACC_W | Signed comb result for the channel in `out_chan` |
| out_valid | output | 1 | High on each beat of an output group |
| out_chan | output | CH_W | Channel index of the current beat |

## Verification
The critical overlap happens when the ratio equals the channel count. In that case the parallel load of new snapshots falls in the same clock as the last beat of the previous group passing through the shared subtractor. The bench sets the ratio to exactly NCH, and also to a smaller value that must clamp to NCH. It then requires every beat of every group to match a scoreboard model in value and channel order. It also requires group starts to be exactly NCH clocks apart, so a dropped or duplicated beat at the seam shows up as a mismatch.

// File: rtl/cic_decim_pkg.sv
package cic_decim_pkg;

    // Width of an index that names one of n items.
    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Accumulator width: input width plus growth for the largest ratio.
    function automatic int grow_bits(input int in_w, input int ratio_w);
        return in_w + ratio_w;
    endfunction

    // Width of a counter that must hold the value n.
    function automatic int count_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl #(
    parameter int NCH     = 6,
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    output logic               load_stb
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
    } rc_state_t;

    localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(NCH);

    rc_state_t          rc_d, rc_q;
    logic [RATIO_W-1:0] eff_ratio;
    logic               stb;

    always_comb begin
        rc_d      = rc_q;
        eff_ratio = (ratio < MIN_RATIO) ? MIN_RATIO : ratio;
        stb       = (rc_q.cnt >= (eff_ratio - 1'b1));
        if (stb) begin
            rc_d.cnt = '0;
        end else begin
            rc_d.cnt = rc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_q <= '0;
        end else begin
            rc_q <= rc_d;
        end
    end

    assign load_stb = stb;

endmodule

// File: rtl/cic_integrator_bank.sv
module cic_integrator_bank #(
    parameter int NCH   = 6,
    parameter int IN_W  = 16,
    parameter int ACC_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*IN_W-1:0]   in_data,
    output logic [NCH*ACC_W-1:0]  acc_flat
);
    localparam int EXT_W = ACC_W - IN_W;

    typedef struct packed {
        logic [NCH-1:0][ACC_W-1:0] acc;
    } ib_state_t;

    ib_state_t                 ib_d, ib_q;
    logic [NCH-1:0][ACC_W-1:0] lane_ext;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic [IN_W-1:0] lane;
        assign lane        = in_data[c*IN_W +: IN_W];
        assign lane_ext[c] = {{EXT_W{lane[IN_W-1]}}, lane};
    end

    always_comb begin
        ib_d = ib_q;
        for (int c = 0; c < NCH; c++) begin
            ib_d.acc[c] = ib_q.acc[c] + lane_ext[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ib_q <= '0;
        end else begin
            ib_q <= ib_d;
        end
    end

    assign acc_flat = ib_q.acc;

endmodule

// File: rtl/cic_conveyor.sv
module cic_conveyor
    import cic_decim_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int ACC_W = 24,
    parameter int CH_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NCH*ACC_W-1:0] acc_flat,
    output logic [ACC_W-1:0]     head,
    output logic                 head_valid,
    output logic [CH_W-1:0]      head_chan
);
    localparam int LEFT_W = count_bits(NCH);

    typedef struct packed {
        logic [NCH-1:0][ACC_W-1:0] slot;
        logic [LEFT_W-1:0]         left;
    } cv_state_t;

    cv_state_t cv_d, cv_q;

    always_comb begin
        cv_d = cv_q;
        if (load) begin
            cv_d.slot = acc_flat;
            cv_d.left = LEFT_W'(NCH);
        end else begin
            for (int i = 0; i < NCH - 1; i++) begin
                cv_d.slot[i] = cv_q.slot[i+1];
            end
            cv_d.slot[NCH-1] = '0;
            if (cv_q.left != '0) begin
                cv_d.left = cv_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_q <= '0;
        end else begin
            cv_q <= cv_d;
        end
    end

    assign head       = cv_q.slot[0];
    assign head_valid = (cv_q.left != '0);
    assign head_chan  = CH_W'(NCH) - CH_W'(cv_q.left);

endmodule

// File: rtl/cic_shared_comb.sv
module cic_shared_comb #(
    parameter int NCH   = 6,
    parameter int ACC_W = 24,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] head,
    input  logic             head_valid,
    input  logic [CH_W-1:0]  head_chan,
    output logic [ACC_W-1:0] out_data,
    output logic             out_valid,
    output logic [CH_W-1:0]  out_chan
);
    typedef struct packed {
        logic [NCH-1:0][ACC_W-1:0] hist;
        logic [ACC_W-1:0]          data;
        logic                      valid;
        logic [CH_W-1:0]           chan;
    } cb_state_t;

    cb_state_t cb_d, cb_q;

    always_comb begin
        cb_d       = cb_q;
        cb_d.valid = head_valid;
        if (head_valid) begin
            // The history advances only on stream beats, so its far end
            // always holds the same channel one period earlier.
            cb_d.data    = head - cb_q.hist[NCH-1];
            cb_d.chan    = head_chan;
            cb_d.hist[0] = head;
            for (int i = 1; i < NCH; i++) begin
                cb_d.hist[i] = cb_q.hist[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cb_q <= '0;
        end else begin
            cb_q <= cb_d;
        end
    end

    assign out_data  = cb_q.data;
    assign out_valid = cb_q.valid;
    assign out_chan  = cb_q.chan;

endmodule

// File: rtl/cic_conveyor_decim.sv
module cic_conveyor_decim
    import cic_decim_pkg::*;
#(
    parameter int NCH     = 6,
    parameter int IN_W    = 16,
    parameter int RATIO_W = 8,
    localparam int ACC_W  = grow_bits(IN_W, RATIO_W),
    localparam int CH_W   = idx_bits(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH*IN_W-1:0] in_data,
    input  logic [RATIO_W-1:0]  ratio,
    output logic [ACC_W-1:0]    out_data,
    output logic                out_valid,
    output logic [CH_W-1:0]     out_chan
);
    logic                 load_stb;
    logic [NCH*ACC_W-1:0] acc_flat;
    logic [ACC_W-1:0]     head;
    logic                 head_valid;
    logic [CH_W-1:0]      head_chan;

    cic_rate_ctrl #(.NCH(NCH), .RATIO_W(RATIO_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio    (ratio),
        .load_stb (load_stb)
    );

    cic_integrator_bank #(.NCH(NCH), .IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .acc_flat (acc_flat)
    );

    cic_conveyor #(.NCH(NCH), .ACC_W(ACC_W), .CH_W(CH_W)) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_stb),
        .acc_flat   (acc_flat),
        .head       (head),
        .head_valid (head_valid),
        .head_chan  (head_chan)
    );

    cic_shared_comb #(.NCH(NCH), .ACC_W(ACC_W), .CH_W(CH_W)) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .head_valid (head_valid),
        .head_chan  (head_chan),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_chan   (out_chan)
    );

endmodule

// File: rtl/cic_decim_checker.sv
module cic_decim_checker #(
    parameter int NCH   = 6,
    parameter int ACC_W = 24,
    parameter int CH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_stb,
    input logic             out_valid,
    input logic [CH_W-1:0]  out_chan,
    input logic [ACC_W-1:0] out_data
);
    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (load_stb) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_load_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && seen_q) |-> (gap_q >= 16'(NCH - 1)));

    assert_first_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_chan == '0));

    assert_chan_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_chan != CH_W'(NCH - 1))) |=>
            (out_valid && (out_chan == CH_W'($past(out_chan) + 1'b1))));

    assert_chan_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(out_chan) < NCH));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

bind cic_conveyor_decim cic_decim_checker #(
    .NCH(NCH), .ACC_W(ACC_W), .CH_W(CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (load_stb),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data)
);

// File: tb/cic_conveyor_decim_test.sv
module cic_conveyor_decim_test;
    localparam int NCH     = 6;
    localparam int IN_W    = 16;
    localparam int RATIO_W = 8;
    localparam int ACC_W   = IN_W + RATIO_W;
    localparam int CH_W    = 3;
    localparam longint FULL_EXP = -32768 * 255;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH*IN_W-1:0] in_data = '0;
    logic [RATIO_W-1:0]  ratio = 8'd8;
    logic [ACC_W-1:0]    out_data;
    logic                out_valid;
    logic [CH_W-1:0]     out_chan;

    always #4 clk = ~clk;

    cic_conveyor_decim #(.NCH(NCH), .IN_W(IN_W), .RATIO_W(RATIO_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .ratio(ratio),
        .out_data(out_data), .out_valid(out_valid), .out_chan(out_chan)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        int               chan;
        logic [ACC_W-1:0] data;
        bit               first;
    } exp_t;
    exp_t q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [ACC_W-1:0] sx(input logic [IN_W-1:0] v);
        return {{(ACC_W-IN_W){v[IN_W-1]}}, v};
    endfunction

    // Scoreboard driver side: reference of the requirements, pushes items
    logic [ACC_W-1:0] m_acc [NCH];
    logic [ACC_W-1:0] m_prev[NCH];
    int m_cnt;
    int m_eff;
    bit m_first;
    exp_t m_item;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_acc[c]  = '0;
                m_prev[c] = '0;
            end
            m_cnt   = 0;
            m_first = 1'b1;
        end else begin
            m_eff = (int'(ratio) < NCH) ? NCH : int'(ratio);
            if (m_cnt >= m_eff - 1) begin
                for (int c = 0; c < NCH; c++) begin
                    m_item.chan  = c;
                    m_item.data  = m_acc[c] - m_prev[c];
                    m_item.first = m_first;
                    q.push_back(m_item);
                    m_prev[c] = m_acc[c];
                end
                m_cnt   = 0;
                m_first = 1'b0;
            end else begin
                m_cnt++;
            end
            for (int c = 0; c < NCH; c++) begin
                m_acc[c] = m_acc[c] + sx(in_data[c*IN_W +: IN_W]);
            end
        end
    end

    // Monitor: pops and compares
    int cyc = 0;
    int last_start = -1;
    int exp_period = 0;
    bit full_chk = 1'b0;
    logic [ACC_W-1:0] last_data = '0;
    exp_t mon_e;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R5", "beat with empty scoreboard", longint'(out_chan), -1);
                end else begin
                    mon_e = q.pop_front();
                    check(int'(out_chan) == mon_e.chan, "R5", "channel index",
                          longint'(out_chan), longint'(mon_e.chan));
                    check(out_data == mon_e.data, mon_e.first ? "R6" : "R2", "channel sum",
                          longint'($signed(out_data)), longint'($signed(mon_e.data)));
                end
                if (full_chk) begin
                    check(longint'($signed(out_data)) == FULL_EXP, "R3", "full-scale sum",
                          longint'($signed(out_data)), FULL_EXP);
                end
                if (out_chan == '0) begin
                    if (exp_period != 0 && last_start >= 0) begin
                        check(cyc - last_start == exp_period,
                              (exp_period == NCH) ? "R8" : "R4", "group period",
                              longint'(cyc - last_start), longint'(exp_period));
                    end
                    last_start = cyc;
                end
            end else begin
                check(out_data == last_data, "R7", "idle hold",
                      longint'($signed(out_data)), longint'($signed(last_data)));
            end
            last_data = out_data;
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    task automatic run(input int n, input int mode);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            for (int c = 0; c < NCH; c++) begin
                case (mode)
                    0: in_data[c*IN_W +: IN_W] = IN_W'((c + 1) * 37 + k * (c + 1) - 300 * c);
                    1: in_data[c*IN_W +: IN_W] = lfsr ^ IN_W'(c * 16'h1357);
                    2: in_data[c*IN_W +: IN_W] = 16'h8000;
                    default: in_data[c*IN_W +: IN_W] = '0;
                endcase
            end
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "valid in reset", longint'(out_valid), 0);
        check(out_data == '0, "R1", "data in reset", longint'(out_data), 0);
        check(out_chan == '0, "R1", "chan in reset", longint'(out_chan), 0);
        rst_n = 1'b1;
        run(4, 0);
        check(out_valid == 1'b0, "R1", "valid before first group", longint'(out_valid), 0);
        check(out_data == '0, "R1", "data before first group", longint'(out_data), 0);
        // R2/R6: ramp inputs, ratio 8
        run(30, 0);
        exp_period = 8;
        run(50, 0);
        exp_period = 0;
        // R8: ratio equal to channel count, pseudo-random inputs
        ratio = 8'd6;
        run(30, 1);
        exp_period = 6;
        run(60, 1);
        exp_period = 0;
        // R4: ratio below channel count clamps to NCH
        ratio = 8'd2;
        run(30, 1);
        exp_period = 6;
        run(60, 1);
        exp_period = 0;
        // R3: full-scale negative input at the largest ratio
        ratio = 8'd255;
        run(800, 2);
        full_chk = 1'b1;
        exp_period = 255;
        run(800, 2);
        full_chk = 1'b0;
        exp_period = 0;
        ratio = 8'd9;
        run(80, 3);
        check(q.size() <= NCH, "R5", "scoreboard backlog", longint'(q.size()), NCH);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule